// File: doc/BRIEF.md
# Dual-Half Timer/Counter with PWM

This block is a 16-bit timer/counter made of two byte-wide halves, a low half and a high half, that a two-bit mode field combines in four ways. In split mode the halves are two independent 8-bit timers, each with its own toggle output. In dual-PWM mode both halves free-run as 8-bit PWM generators. In cascaded mode the halves form one 16-bit timer or event counter. In cascaded-PWM mode the halves form one 16-bit timer whose low byte also drives a PWM output.

A shared programmable prescaler divides an enable strobe taken from the system cycle clock. The high half, or the whole cascaded counter, can instead count pulses on an external event strobe. Software programs the block through a write-only register port. It sees events on two sticky interrupt flags, one per half, and clears each flag by writing a 1 to it.

Top module: `dual_half_timer`

## Requirements
- R1: After reset all six outputs are low, the mode is split (0), counting is stopped, every counter is zero, the prescaler divisor and the duties are zero, and both match values are all ones.
- R2: A write with wr_en high stores wr_data at wr_addr. The address map is: 0 mode (bits 1:0; 0 split, 1 dual PWM, 2 cascaded, 3 cascaded PWM), 1 config (bit0 run, bit1 low toggle enable, bit2 high toggle enable, bit3 high source is ext_evt), 2 prescaler divisor P, 3 low match, 4 high match, 5 low duty, 6 high duty, 7 flag clear (bit0 low, bit1 high).
- R3: While run is set, the prescaler gives one tick for every P+1 cycles in which cyc_tick is high. While run is clear, no counter moves.
- R4: In split mode each half counts prescaler ticks up from zero. On the tick where its count equals its match value it returns to zero, sets its flag and, if its toggle is enabled, inverts its toggle output. The period is therefore match+1 ticks.
- R5: When config bit3 is set in split or cascaded mode, the high half (in split mode) or the whole 16-bit counter (in cascaded mode) advances once per clock in which ext_evt is high. This happens only while run is set.
- R6: In dual-PWM mode both halves wrap through 256 ticks. Each PWM output is high while its count is below its duty. Each flag is set when its half wraps from 255 to 0.
- R7: A duty of 0 holds the PWM output low. A duty of 255 makes it high for 255 of every 256 counts.
- R8: In cascaded mode the 16-bit count runs from 0 to {high match, low match}. On the tick at that value it returns to zero, sets the high flag and toggles tgl_hi if enabled. On any tick where the low byte equals the low match, it sets the low flag and toggles tgl_lo if enabled.
- R9: In cascaded-PWM mode the 16-bit timer counts only prescaler ticks and wraps as in R8, with the high flag and tgl_hi. pwm_lo is high while the low byte is below the low duty. The low flag is set on a carry from the low byte, and tgl_lo does not change.
- R10: A write to the mode register clears run, both counters, the prescaler and both toggle outputs. Flags are kept. Counting resumes only after run is written again.
- R11: Flags are sticky until cleared by writing 1 to the matching bit of the flag-clear register. A new event in the same cycle as a clear wins.
- R12: pwm_lo and pwm_hi are low in split and cascaded modes, and pwm_hi is low in cascaded-PWM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | System cycle enable that feeds the prescaler |
| ext_evt | input | 1 | External event strobe, one count per high clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | HALF_W (8) | Register write data |
| tgl_lo | output | 1 | Low-half toggle output |
| tgl_hi | output | 1 | High-half / 16-bit toggle output |
| pwm_lo | output | 1 | Low-byte PWM output |
| pwm_hi | output | 1 | High-byte PWM output |
| irq_lo | output | 1 | Low-half sticky interrupt flag |
| irq_hi | output | 1 | High-half sticky interrupt flag |

## Verification
The bench builds the block with its defaults, HALF_W = 8 and PRE_W = 8. With these values the 256-count PWM period and both duty extremes (0 and 255) can be reached in a few hundred cycles. Cascaded match values above 255 can be reached in the same span, so the high half's carry and the 16-bit wrap are both exercised. Small prescaler divisors (1 and 2) check the P+1 tick spacing. External-strobe runs check event counting and show that ext_evt is ignored while run is clear.

// File: rtl/dht_pkg.sv
package dht_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      MODE_SPLIT    = 2'd0,
      MODE_PWM2     = 2'd1,
      MODE_CASC     = 2'd2,
      MODE_CASC_PWM = 2'd3
   } dht_mode_e;

   localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CFG   = 3'd1;
   localparam logic [ADDR_W-1:0] A_PRE   = 3'd2;
   localparam logic [ADDR_W-1:0] A_MLO   = 3'd3;
   localparam logic [ADDR_W-1:0] A_MHI   = 3'd4;
   localparam logic [ADDR_W-1:0] A_DLO   = 3'd5;
   localparam logic [ADDR_W-1:0] A_DHI   = 3'd6;
   localparam logic [ADDR_W-1:0] A_FCLR  = 3'd7;
endpackage

// File: rtl/dht_prescaler.sv
module dht_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   logic [PRE_W-1:0] pcnt_q;

   assign tick = en && (pcnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (clr)
         pcnt_q <= '0;
      else if (en)
         pcnt_q <= (pcnt_q == div) ? '0 : pcnt_q + 1'b1;
   end
endmodule

// File: rtl/dht_half.sv
module dht_half #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         wrap,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (step)
         cnt <= wrap ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/dht_regs.sv
module dht_regs
   import dht_pkg::*;
#(
   parameter int HALF_W = 8,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [HALF_W-1:0] wr_data,
   output dht_mode_e         mode,
   output logic              run,
   output logic              ten_lo,
   output logic              ten_hi,
   output logic              hi_ext,
   output logic [PRE_W-1:0]  pre_div,
   output logic [HALF_W-1:0] match_lo,
   output logic [HALF_W-1:0] match_hi,
   output logic [HALF_W-1:0] duty_lo,
   output logic [HALF_W-1:0] duty_hi,
   output logic              mode_wr,
   output logic              fclr_lo,
   output logic              fclr_hi
);
   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data[HALF_W-1:4];

   assign mode_wr = wr_en && (wr_addr == A_MODE);
   assign fclr_lo = wr_en && (wr_addr == A_FCLR) && wr_data[0];
   assign fclr_hi = wr_en && (wr_addr == A_FCLR) && wr_data[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= MODE_SPLIT;
         run      <= 1'b0;
         ten_lo   <= 1'b0;
         ten_hi   <= 1'b0;
         hi_ext   <= 1'b0;
         pre_div  <= '0;
         match_lo <= '1;
         match_hi <= '1;
         duty_lo  <= '0;
         duty_hi  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_MODE: begin
               mode <= dht_mode_e'(wr_data[1:0]);
               run  <= 1'b0;
            end
            A_CFG: begin
               run    <= wr_data[0];
               ten_lo <= wr_data[1];
               ten_hi <= wr_data[2];
               hi_ext <= wr_data[3];
            end
            A_PRE:   pre_div  <= wr_data[PRE_W-1:0];
            A_MLO:   match_lo <= wr_data;
            A_MHI:   match_hi <= wr_data;
            A_DLO:   duty_lo  <= wr_data;
            A_DHI:   duty_hi  <= wr_data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
   import dht_pkg::*;
#(
   parameter int HALF_W = 8,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_tick,
   input  logic              ext_evt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [HALF_W-1:0] wr_data,
   output logic              tgl_lo,
   output logic              tgl_hi,
   output logic              pwm_lo,
   output logic              pwm_hi,
   output logic              irq_lo,
   output logic              irq_hi
);
   localparam int NHALF = 2;

   generate
      if (HALF_W < 4) begin : g_bad_half
         $error("dual_half_timer: HALF_W must be at least 4");
      end
      if (PRE_W < 1 || PRE_W > HALF_W) begin : g_bad_pre
         $error("dual_half_timer: PRE_W must lie in 1..HALF_W");
      end
   endgenerate

   dht_mode_e         mode;
   logic              run, ten_lo, ten_hi, hi_ext, mode_wr, fclr_lo, fclr_hi;
   logic [PRE_W-1:0]  pre_div;
   logic [HALF_W-1:0] match_lo, match_hi, duty_lo, duty_hi;

   dht_regs #(.HALF_W(HALF_W), .PRE_W(PRE_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .mode(mode), .run(run), .ten_lo(ten_lo), .ten_hi(ten_hi), .hi_ext(hi_ext),
      .pre_div(pre_div), .match_lo(match_lo), .match_hi(match_hi),
      .duty_lo(duty_lo), .duty_hi(duty_hi), .mode_wr(mode_wr),
      .fclr_lo(fclr_lo), .fclr_hi(fclr_hi)
   );

   logic tick;
   dht_prescaler #(.PRE_W(PRE_W)) pre_i (
      .clk(clk), .rst_n(rst_n), .clr(mode_wr), .en(run && cyc_tick),
      .div(pre_div), .tick(tick)
   );

   logic [HALF_W-1:0] cnt_v [NHALF];
   logic [NHALF-1:0]  step_v, wrap_v;

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      dht_half #(.W(HALF_W)) half_i (
         .clk(clk), .rst_n(rst_n), .clr(mode_wr),
         .step(step_v[h]), .wrap(wrap_v[h]), .cnt(cnt_v[h])
      );
   end

   logic [HALF_W-1:0] cnt_lo, cnt_hi;
   assign cnt_lo = cnt_v[0];
   assign cnt_hi = cnt_v[1];

   logic ext_step, hi_src, lo_top, hi_top, full_top, lo_ones, hi_ones;
   assign ext_step = run && ext_evt;
   assign hi_src   = hi_ext ? ext_step : tick;
   assign lo_top   = (cnt_lo == match_lo);
   assign hi_top   = (cnt_hi == match_hi);
   assign full_top = lo_top && hi_top;
   assign lo_ones  = &cnt_lo;
   assign hi_ones  = &cnt_hi;

   logic ev_lo, ev_hi, tg_lo, tg_hi;

   always_comb begin
      step_v = '0;
      wrap_v = '0;
      ev_lo  = 1'b0;
      ev_hi  = 1'b0;
      tg_lo  = 1'b0;
      tg_hi  = 1'b0;
      case (mode)
         MODE_SPLIT: begin
            step_v = {hi_src, tick};
            wrap_v = {hi_top, lo_top};
            ev_lo  = tick && lo_top;
            ev_hi  = hi_src && hi_top;
            tg_lo  = ev_lo;
            tg_hi  = ev_hi;
         end
         MODE_PWM2: begin
            step_v = {tick, tick};
            ev_lo  = tick && lo_ones;
            ev_hi  = tick && hi_ones;
         end
         MODE_CASC: begin
            step_v = {hi_src && (full_top || lo_ones), hi_src};
            wrap_v = {full_top, full_top};
            ev_lo  = hi_src && lo_top;
            ev_hi  = hi_src && full_top;
            tg_lo  = ev_lo;
            tg_hi  = ev_hi;
         end
         MODE_CASC_PWM: begin
            step_v = {tick && (full_top || lo_ones), tick};
            wrap_v = {full_top, full_top};
            ev_lo  = tick && lo_ones && !full_top;
            ev_hi  = tick && full_top;
            tg_hi  = ev_hi;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_lo <= 1'b0;
         tgl_hi <= 1'b0;
         irq_lo <= 1'b0;
         irq_hi <= 1'b0;
      end else begin
         if (mode_wr) begin
            tgl_lo <= 1'b0;
            tgl_hi <= 1'b0;
         end else begin
            if (tg_lo && ten_lo) tgl_lo <= ~tgl_lo;
            if (tg_hi && ten_hi) tgl_hi <= ~tgl_hi;
         end
         irq_lo <= ev_lo || (irq_lo && !fclr_lo);
         irq_hi <= ev_hi || (irq_hi && !fclr_hi);
      end
   end

   assign pwm_lo = ((mode == MODE_PWM2) || (mode == MODE_CASC_PWM)) && (cnt_lo < duty_lo);
   assign pwm_hi = (mode == MODE_PWM2) && (cnt_hi < duty_hi);
endmodule

// File: rtl/dht_checker.sv
module dht_checker
   import dht_pkg::*;
#(
   parameter int HALF_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wd0,
   input logic              wd1,
   input logic [1:0]        mode,
   input logic              run,
   input logic [HALF_W-1:0] cnt_lo,
   input logic [HALF_W-1:0] cnt_hi,
   input logic [HALF_W-1:0] duty_lo,
   input logic [HALF_W-1:0] duty_hi,
   input logic              pwm_lo,
   input logic              pwm_hi,
   input logic              irq_lo,
   input logic              irq_hi
);
   logic mwr, clr_lo, clr_hi;
   assign mwr    = wr_en && (wr_addr == A_MODE);
   assign clr_lo = wr_en && (wr_addr == A_FCLR) && wd0;
   assign clr_hi = wr_en && (wr_addr == A_FCLR) && wd1;

   assert_flag_lo_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lo && !clr_lo) |=> irq_lo);
   assert_flag_hi_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_hi && !clr_hi) |=> irq_hi);
   assert_mode_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mwr |=> (cnt_lo == '0 && cnt_hi == '0 && !run));
   assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !mwr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
   assert_pwm_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 || mode == 2'd2) |-> (!pwm_lo && !pwm_hi));
   assert_duty_zero_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_lo == '0) |-> !pwm_lo);
   assert_duty_zero_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_hi == '0) |-> !pwm_hi);
endmodule

bind dual_half_timer dht_checker #(.HALF_W(HALF_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wd0(wr_data[0]), .wd1(wr_data[1]), .mode(mode), .run(run),
   .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .duty_lo(duty_lo), .duty_hi(duty_hi),
   .pwm_lo(pwm_lo), .pwm_hi(pwm_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/dual_half_timer_tb_top.sv
module dual_half_timer_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_tick = 1'b1;
   logic ext_evt = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic tgl_lo, tgl_hi, pwm_lo, pwm_hi, irq_lo, irq_hi;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_half_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_evt(ext_evt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tgl_lo(tgl_lo), .tgl_hi(tgl_hi), .pwm_lo(pwm_lo), .pwm_hi(pwm_hi),
      .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   // mode, prescale, match lo/hi, duty lo/hi, cfg, cycles, expected {tgl_lo,tgl_hi,pwm_lo,pwm_hi,irq_lo,irq_hi}
   typedef struct packed {
      logic [1:0]  mode;
      logic [7:0]  pre;
      logic [7:0]  mlo;
      logic [7:0]  mhi;
      logic [7:0]  dlo;
      logic [7:0]  dhi;
      logic [3:0]  cfg;
      logic [15:0] n;
      logic [5:0]  exp;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 8'd0, 8'd3,  8'd5, 8'd0,   8'd0,   4'd7, 16'd10,  6'b010011}, // R4 split timers
      '{2'd0, 8'd1, 8'd2,  8'd7, 8'd0,   8'd0,   4'd7, 16'd9,   6'b100010}, // R3 prescale by 2
      '{2'd0, 8'd0, 8'd4,  8'd0, 8'd0,   8'd0,   4'd5, 16'd7,   6'b010011}, // R4 toggle disabled, match 0
      '{2'd1, 8'd0, 8'd0,  8'd0, 8'd5,   8'd2,   4'd1, 16'd3,   6'b001000}, // R6 dual PWM
      '{2'd1, 8'd0, 8'd0,  8'd0, 8'd0,   8'd255, 4'd1, 16'd255, 6'b000000}, // R7 duty extremes, last count
      '{2'd1, 8'd0, 8'd0,  8'd0, 8'd0,   8'd255, 4'd1, 16'd256, 6'b000111}, // R7 R6 wrap
      '{2'd2, 8'd0, 8'd2,  8'd1, 8'd0,   8'd0,   4'd7, 16'd100, 6'b100010}, // R8 low byte match
      '{2'd2, 8'd0, 8'd2,  8'd1, 8'd0,   8'd0,   4'd7, 16'd260, 6'b010011}, // R8 full 16-bit wrap
      '{2'd3, 8'd0, 8'd16, 8'd1, 8'd128, 8'd0,   4'd7, 16'd300, 6'b011011}, // R9 16-bit with PWM
      '{2'd3, 8'd1, 8'd16, 8'd1, 8'd128, 8'd0,   4'd7, 16'd20,  6'b001000}, // R9 R3 prescaled
      '{2'd2, 8'd2, 8'd5,  8'd0, 8'd0,   8'd0,   4'd7, 16'd18,  6'b110011}  // R8 R3 divide by 3
   };

   task automatic chk(input string what, input logic got, input logic exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", what, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_ext(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ext_evt = 1'b1;
         @(negedge clk);
         ext_evt = 1'b0;
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 tgl_lo", tgl_lo, 1'b0);
      chk("R1 tgl_hi", tgl_hi, 1'b0);
      chk("R1 pwm_lo", pwm_lo, 1'b0);
      chk("R1 pwm_hi", pwm_hi, 1'b0);
      chk("R1 irq_lo", irq_lo, 1'b0);
      chk("R1 irq_hi", irq_hi, 1'b0);
      rst_n = 1'b1;
      wait_edges(2);
      chk("R1 idle after reset irq_lo", irq_lo, 1'b0);

      // vector table, all registers programmed through the R2 address map
      for (int v = 0; v < NVEC; v++) begin
         wr(3'd0, {6'd0, VECS[v].mode});
         wr(3'd7, 8'd3);
         wr(3'd2, VECS[v].pre);
         wr(3'd3, VECS[v].mlo);
         wr(3'd4, VECS[v].mhi);
         wr(3'd5, VECS[v].dlo);
         wr(3'd6, VECS[v].dhi);
         wr(3'd1, {4'd0, VECS[v].cfg});
         wait_edges(int'(VECS[v].n));
         chk($sformatf("R2 vec%0d tgl_lo", v), tgl_lo, VECS[v].exp[5]);
         chk($sformatf("R2 vec%0d tgl_hi", v), tgl_hi, VECS[v].exp[4]);
         chk($sformatf("R2 vec%0d pwm_lo", v), pwm_lo, VECS[v].exp[3]);
         chk($sformatf("R2 vec%0d pwm_hi", v), pwm_hi, VECS[v].exp[2]);
         chk($sformatf("R2 vec%0d irq_lo", v), irq_lo, VECS[v].exp[1]);
         chk($sformatf("R2 vec%0d irq_hi", v), irq_hi, VECS[v].exp[0]);
      end

      // R5 external event counting on the high half
      wr(3'd0, 8'd0);
      wr(3'd7, 8'd3);
      wr(3'd2, 8'd0);
      wr(3'd3, 8'd255);
      wr(3'd4, 8'd1);
      wr(3'd1, 8'd13);
      pulse_ext(3);
      chk("R5 ext tgl_hi", tgl_hi, 1'b1);
      chk("R5 ext irq_hi", irq_hi, 1'b1);
      chk("R5 ext irq_lo", irq_lo, 1'b0);
      wr(3'd1, 8'd12);
      wr(3'd7, 8'd3);
      pulse_ext(4);
      chk("R5 ext ignored when stopped irq_hi", irq_hi, 1'b0);
      chk("R5 ext ignored when stopped tgl_hi", tgl_hi, 1'b1);

      // R10 mode write stops, clears toggles, keeps flags
      wr(3'd0, 8'd0);
      wr(3'd7, 8'd3);
      wr(3'd3, 8'd0);
      wr(3'd1, 8'd3);
      wait_edges(3);
      chk("R10 running tgl_lo", tgl_lo, 1'b1);
      wr(3'd0, 8'd0);
      @(negedge clk);
      chk("R10 flag kept", irq_lo, 1'b1);
      chk("R10 toggle cleared", tgl_lo, 1'b0);
      wr(3'd7, 8'd3);
      wait_edges(20);
      chk("R10 stopped irq_lo", irq_lo, 1'b0);
      wr(3'd1, 8'd1);
      wait_edges(1);
      chk("R10 resumes irq_lo", irq_lo, 1'b1);

      // R11 sticky flags and per-bit clear
      wr(3'd0, 8'd0);
      wr(3'd3, 8'd0);
      wr(3'd4, 8'd0);
      wr(3'd1, 8'd1);
      wait_edges(2);
      wr(3'd0, 8'd0);
      wait_edges(10);
      chk("R11 sticky irq_lo", irq_lo, 1'b1);
      chk("R11 sticky irq_hi", irq_hi, 1'b1);
      wr(3'd7, 8'd1);
      @(negedge clk);
      chk("R11 clear lo only irq_lo", irq_lo, 1'b0);
      chk("R11 clear lo only irq_hi", irq_hi, 1'b1);
      wr(3'd7, 8'd2);
      @(negedge clk);
      chk("R11 clear hi irq_hi", irq_hi, 1'b0);

      // R12 PWM outputs idle outside PWM modes
      wr(3'd5, 8'd255);
      wr(3'd6, 8'd255);
      wr(3'd1, 8'd1);
      wait_edges(5);
      chk("R12 split pwm_lo", pwm_lo, 1'b0);
      chk("R12 split pwm_hi", pwm_hi, 1'b0);
      wr(3'd0, 8'd2);
      wr(3'd1, 8'd1);
      wait_edges(5);
      chk("R12 cascaded pwm_lo", pwm_lo, 1'b0);
      chk("R12 cascaded pwm_hi", pwm_hi, 1'b0);
      wr(3'd0, 8'd3);
      wr(3'd1, 8'd1);
      wait_edges(5);
      chk("R12 cascaded-pwm pwm_lo", pwm_lo, 1'b1);
      chk("R12 cascaded-pwm pwm_hi", pwm_hi, 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule